// File: doc/BRIEF.md
# I2C Single-Master Command Controller

This block runs an I2C bus as its only master. A small command interface asks for one bus operation at a time: a Start, a Repeated Start, a Stop, a byte receive with a chosen acknowledge value, or a byte transmit. A byte transmit is started by writing the byte. The block generates every SCL pulse and every Start and Stop condition itself. Both lines are open-drain. An output pulls its line low when high and releases the line otherwise. The block reads the real line levels back through two inputs.

Operations are not queued. While an operation runs, further commands are ignored. A data write made at that time is dropped and sets a sticky write-collision flag. Every completed bus event sets a single sticky interrupt flag, and that flag is cleared only by an explicit clear. The block also watches the lines for Start and Stop conditions and reports whether the bus is free.

The FSM states are S_IDLE, S_START, S_HOLD, S_RSTART, S_STOP, S_TXBIT, S_TXACK, S_RXBIT and S_RXACK. In S_IDLE both lines are released. S_HOLD is the bus-owned rest state, with SCL held low. The transitions are:
- S_IDLE to S_START on a Start command.
- S_HOLD to S_RSTART, S_STOP or S_RXBIT on the matching command.
- S_HOLD to S_TXBIT on a data write.
- S_TXBIT to S_TXACK, and S_RXBIT to S_RXACK, after the last data bit.
- S_START, S_RSTART, S_TXACK and S_RXACK back to S_HOLD when they complete.
- S_STOP to S_IDLE when it completes.
- Any state to S_IDLE when the enable input is low.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset, scl_oe and sda_oe are 0 (both lines released), and busy, irq and wcol are 0. bus_free is 1.
- R2: During a byte, SCL has a period of 4 × (div + 1) clock cycles. A period is split into four quarters of div + 1 cycles each.
- R3: A Start command (cmd_op = 0), accepted only when the bus is not owned, does the following:
  - pulls SDA low while SCL is released, then pulls SCL low;
  - on completion, drops start_busy and sets irq;
  - leaves the bus owned, with SCL held low.
- R4: A write on tx_wr while the bus is owned and no operation runs transmits tx_byte MSB first, as follows:
  - SDA changes only while SCL is low;
  - a ninth clock samples the slave's acknowledge into ack_stat (1 = NACK, line high);
  - irq is set at the end of that ninth clock.
- R5: A Receive command (cmd_op = 3) works as follows:
  - it samples 8 bits, MSB first, on the SCL rising edges;
  - on the ninth clock it drives the cmd_ack value given with the command (0 = ACK, SDA pulled low);
  - the byte is stored in rx_data, which holds until the next receive completes;
  - irq is set.
- R6: A Repeated Start command (cmd_op = 1) makes a new Start condition without any Stop. The bus stays owned, start_busy drops and irq is set.
- R7: A Stop command (cmd_op = 2) does the following:
  - releases SDA while SCL is released;
  - leaves both lines released;
  - drops stop_busy and sets irq.
- R8: A tx_wr made while any operation is in progress (busy = 1) sets wcol and starts no transfer. The bus stays idle-owned after the running operation ends.
- R9: irq and wcol stay set until clr_irq or clr_wcol is pulsed. If a set and a clear happen in the same cycle, the set wins.
- R10: A command issued while busy is ignored. So is a command that does not fit the bus state: Start while the bus is owned, or Stop, Repeated Start or Receive while it is not owned.
- R11: The line monitor works as follows:
  - start_seen is set on an SDA fall while SCL is high, and stop_seen on an SDA rise while SCL is high; each event clears the other flag;
  - both flags are cleared by reset and while en is 0;
  - bus_free is stop_seen OR NOT start_seen.
- R12: While en is 0, the controller returns to idle, releases both lines and ignores all commands and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Controller enable |
| div | input | DIV_W | SCL divider; quarter period = div + 1 clocks |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 Start, 1 Repeated Start, 2 Stop, 3 Receive |
| cmd_ack | input | 1 | Acknowledge to send after a received byte (0 = ACK) |
| tx_wr | input | 1 | Data write strobe; starts a transmit |
| tx_byte | input | DATA_W | Byte to transmit |
| clr_irq | input | 1 | Clears irq |
| clr_wcol | input | 1 | Clears wcol |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | An operation is in progress |
| start_busy | output | 1 | Start or Repeated Start in progress |
| stop_busy | output | 1 | Stop in progress |
| irq | output | 1 | Sticky event flag |
| wcol | output | 1 | Sticky write-collision flag |
| ack_stat | output | 1 | Last acknowledge from the slave, 1 = NACK |
| rx_data | output | DATA_W | Last received byte |
| start_seen | output | 1 | Start condition observed on the lines |
| stop_seen | output | 1 | Stop condition observed on the lines |
| bus_free | output | 1 | Bus counted as free |

## Verification
Transmits and receives use random bytes, random acknowledge values and random divider settings, including the minimum divider of zero. This separates bit-order and bit-count faults from timing faults in the quarter counter. A line model on the bench records the SDA level at each SCL rise, counts Start and Stop conditions, and stamps SCL periods, so a glitch on SDA during data shows up as a spurious condition. Directed cases cover the following:
- writes during Start and Stop, to check the collision flag;
- out-of-place and busy-time commands;
- Repeated Start without a Stop;
- dropping the enable while the bus is owned.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    typedef enum logic [3:0] {
        S_IDLE   = 4'd0,
        S_START  = 4'd1,
        S_HOLD   = 4'd2,
        S_RSTART = 4'd3,
        S_STOP   = 4'd4,
        S_TXBIT  = 4'd5,
        S_TXACK  = 4'd6,
        S_RXBIT  = 4'd7,
        S_RXACK  = 4'd8
    } mst_state_t;

    typedef enum logic [1:0] {
        OP_START  = 2'd0,
        OP_RSTART = 2'd1,
        OP_STOP   = 2'd2,
        OP_RECV   = 2'd3
    } mst_op_t;

endpackage

// File: rtl/i2cm_qtick.sv
// Quarter-period timer: each SCL period is four quarters of (div+1) clocks.
module i2cm_qtick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic [1:0]       q,
    output logic             tick,
    output logic             last
);

    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            q   <= 2'd0;
        end else if (!run) begin
            cnt <= '0;
            q   <= 2'd0;
        end else if (cnt == div) begin
            cnt <= '0;
            q   <= q + 2'd1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == div);
    assign last = tick && (q == 2'd3);

endmodule

// File: rtl/i2cm_shifter.sv
// Shared shift register: transmit shifts out MSB first, receive shifts in at LSB.
module i2cm_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         shift_tx,
    input  logic         shift_rx,
    input  logic         rx_bit,
    output logic         msb,
    output logic [W-1:0] word
);

    logic [W-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= '0;
        end else if (load) begin
            sh <= din;
        end else if (shift_rx) begin
            sh <= {sh[W-2:0], rx_bit};
        end else if (shift_tx) begin
            sh <= {sh[W-2:0], 1'b1};
        end
    end

    assign msb  = sh[W-1];
    assign word = sh;

endmodule

// File: rtl/i2cm_busmon.sv
// Watches the lines for Start and Stop conditions.
module i2cm_busmon (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic scl_in,
    input  logic sda_in,
    output logic start_seen,
    output logic stop_seen,
    output logic bus_free
);

    logic scl_q, sda_q;
    logic start_ev, stop_ev;

    assign start_ev = scl_q && scl_in && sda_q && !sda_in;
    assign stop_ev  = scl_q && scl_in && !sda_q && sda_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q      <= 1'b1;
            sda_q      <= 1'b1;
            start_seen <= 1'b0;
            stop_seen  <= 1'b0;
        end else begin
            scl_q <= scl_in;
            sda_q <= sda_in;
            if (!en) begin
                start_seen <= 1'b0;
                stop_seen  <= 1'b0;
            end else if (start_ev) begin
                start_seen <= 1'b1;
                stop_seen  <= 1'b0;
            end else if (stop_ev) begin
                start_seen <= 1'b0;
                stop_seen  <= 1'b1;
            end
        end
    end

    assign bus_free = stop_seen || !start_seen;

endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
    import i2cm_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DIV_W-1:0]  div,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic              cmd_ack,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              clr_irq,
    input  logic              clr_wcol,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              busy,
    output logic              start_busy,
    output logic              stop_busy,
    output logic              irq,
    output logic              wcol,
    output logic              ack_stat,
    output logic [DATA_W-1:0] rx_data,
    output logic              start_seen,
    output logic              stop_seen,
    output logic              bus_free
);

    localparam int            BW       = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

    mst_state_t state, nstate;
    mst_op_t    op;
    logic       cmd_go, wr_go;
    logic [1:0] q;
    logic       tick, last, sample;
    logic       run;
    logic [BW-1:0] bitcnt;
    logic       ack_drv;
    logic       sh_load, sh_tx, sh_rx, sh_msb;
    logic [DATA_W-1:0] sh_word;
    logic       ev_done;

    assign op     = mst_op_t'(cmd_op);
    assign cmd_go = en && cmd_valid;
    assign wr_go  = en && tx_wr && !cmd_valid;
    assign busy   = (state != S_IDLE) && (state != S_HOLD);
    assign run    = busy;
    assign sample = tick && (q == 2'd1);

    assign start_busy = (state == S_START) || (state == S_RSTART);
    assign stop_busy  = (state == S_STOP);

    i2cm_qtick #(.DIV_W(DIV_W)) u_qtick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .div  (div),
        .q    (q),
        .tick (tick),
        .last (last)
    );

    assign sh_load = (state == S_HOLD) && (nstate == S_TXBIT);
    assign sh_tx   = (state == S_TXBIT) && last;
    assign sh_rx   = (state == S_RXBIT) && sample;

    i2cm_shifter #(.W(DATA_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (sh_load),
        .din     (tx_byte),
        .shift_tx(sh_tx),
        .shift_rx(sh_rx),
        .rx_bit  (sda_in),
        .msb     (sh_msb),
        .word    (sh_word)
    );

    i2cm_busmon u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .start_seen(start_seen),
        .stop_seen (stop_seen),
        .bus_free  (bus_free)
    );

    // Next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE: begin
                if (cmd_go && op == OP_START) nstate = S_START;
            end
            S_HOLD: begin
                if (cmd_go) begin
                    unique case (op)
                        OP_RSTART: nstate = S_RSTART;
                        OP_STOP:   nstate = S_STOP;
                        OP_RECV:   nstate = S_RXBIT;
                        OP_START:  nstate = S_HOLD;
                    endcase
                end else if (wr_go) begin
                    nstate = S_TXBIT;
                end
            end
            S_START:  if (last) nstate = S_HOLD;
            S_RSTART: if (last) nstate = S_HOLD;
            S_STOP:   if (last) nstate = S_IDLE;
            S_TXBIT:  if (last && bitcnt == '0) nstate = S_TXACK;
            S_TXACK:  if (last) nstate = S_HOLD;
            S_RXBIT:  if (last && bitcnt == '0) nstate = S_RXACK;
            S_RXACK:  if (last) nstate = S_HOLD;
            default:  nstate = S_IDLE;
        endcase
        if (!en) nstate = S_IDLE;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    assign ev_done = last && en &&
                     ((state == S_START) || (state == S_RSTART) || (state == S_STOP) ||
                      (state == S_TXACK) || (state == S_RXACK));

    // Datapath and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt   <= '0;
            ack_drv  <= 1'b1;
            ack_stat <= 1'b0;
            rx_data  <= '0;
            irq      <= 1'b0;
            wcol     <= 1'b0;
        end else begin
            if ((state == S_HOLD) && ((nstate == S_TXBIT) || (nstate == S_RXBIT)))
                bitcnt <= LAST_BIT;
            else if (last && ((state == S_TXBIT) || (state == S_RXBIT)) && (bitcnt != '0))
                bitcnt <= bitcnt - 1'b1;

            if ((state == S_HOLD) && (nstate == S_RXBIT))
                ack_drv <= cmd_ack;

            if ((state == S_TXACK) && sample)
                ack_stat <= sda_in;

            if ((state == S_RXACK) && last)
                rx_data <= sh_word;

            if (ev_done)      irq <= 1'b1;
            else if (clr_irq) irq <= 1'b0;

            if (en && tx_wr && busy) wcol <= 1'b1;
            else if (clr_wcol)       wcol <= 1'b0;
        end
    end

    // Line drive per state and quarter
    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        unique case (state)
            S_IDLE: begin
                scl_oe = 1'b0;
                sda_oe = 1'b0;
            end
            S_START: begin
                scl_oe = (q == 2'd3);
                sda_oe = (q != 2'd0);
            end
            S_HOLD: begin
                scl_oe = 1'b1;
                sda_oe = 1'b0;
            end
            S_RSTART: begin
                scl_oe = (q == 2'd0) || (q == 2'd3);
                sda_oe = (q == 2'd2) || (q == 2'd3);
            end
            S_STOP: begin
                scl_oe = (q == 2'd0);
                sda_oe = (q != 2'd3);
            end
            S_TXBIT: begin
                scl_oe = (q == 2'd0) || (q == 2'd3);
                sda_oe = !sh_msb;
            end
            S_TXACK, S_RXBIT: begin
                scl_oe = (q == 2'd0) || (q == 2'd3);
                sda_oe = 1'b0;
            end
            S_RXACK: begin
                scl_oe = (q == 2'd0) || (q == 2'd3);
                sda_oe = !ack_drv;
            end
            default: begin
                scl_oe = 1'b0;
                sda_oe = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/i2cm_chk.sv
module i2cm_chk
    import i2cm_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input mst_state_t state,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       busy,
    input logic       start_busy,
    input logic       stop_busy,
    input logic       tx_wr,
    input logic       clr_irq,
    input logic       clr_wcol,
    input logic       irq,
    input logic       wcol,
    input logic       start_seen,
    input logic       stop_seen
);

    logic data_st;
    assign data_st = (state == S_TXBIT) || (state == S_TXACK) ||
                     (state == S_RXBIT) || (state == S_RXACK);

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> (!scl_oe && !sda_oe)); // R1

    AST_START_DONE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(start_busy) && $past(en)) |-> (irq && state == S_HOLD)); // R3

    AST_DATA_SDA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (data_st && !scl_oe && !$past(scl_oe) && $past(state) == state) |-> $stable(sda_oe)); // R4

    AST_STOP_DONE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(stop_busy) && $past(en)) |-> (irq && !scl_oe && !sda_oe)); // R7

    AST_WCOL_ON_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tx_wr && busy) |=> wcol); // R8

    AST_WCOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (wcol && !clr_wcol) |=> wcol); // R9

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_irq) |=> irq); // R9

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |=> (!start_seen && !stop_seen && state == S_IDLE)); // R11

endmodule

bind i2c_cmd_master i2cm_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .state     (state),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .busy      (busy),
    .start_busy(start_busy),
    .stop_busy (stop_busy),
    .tx_wr     (tx_wr),
    .clr_irq   (clr_irq),
    .clr_wcol  (clr_wcol),
    .irq       (irq),
    .wcol      (wcol),
    .start_seen(start_seen),
    .stop_seen (stop_seen)
);

// File: tb/tb_i2c_cmd_master.sv
module tb_i2c_cmd_master;

    localparam int DIV_W  = 8;
    localparam int DATA_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b1;
    logic [DIV_W-1:0] div = '0;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic cmd_ack = 1'b0;
    logic tx_wr = 1'b0;
    logic [DATA_W-1:0] tx_byte = '0;
    logic clr_irq = 1'b0;
    logic clr_wcol = 1'b0;
    logic scl_in, sda_in;
    logic scl_oe, sda_oe, busy, start_busy, stop_busy, irq, wcol, ack_stat;
    logic [DATA_W-1:0] rx_data;
    logic start_seen, stop_seen, bus_free;

    always #2 clk = ~clk;

    // Slave / line model
    int mode = 0;            // 0 silent, 1 write target, 2 read source
    logic slv_nack = 1'b0;
    logic [DATA_W-1:0] slv_byte = '0;
    int fall_cnt = 0, rise_cnt = 0, base = 0;
    int n_start = 0, n_stop = 0;
    int cyc = 0, prev_rise = 0, last_rise = 0;
    logic [DATA_W:0] cap = '0;
    logic slv_pull;
    logic scl_p = 1'b1, sda_p = 1'b1;
    int idx;

    assign idx = fall_cnt - base;
    assign slv_pull = (mode == 1) ? (idx == DATA_W && !slv_nack) :
                      (mode == 2) ? (idx < DATA_W && !slv_byte[DATA_W-1-idx]) : 1'b0;
    assign scl_in = !scl_oe;
    assign sda_in = !(sda_oe || slv_pull);

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n) begin
            if (!scl_p && scl_in) begin
                rise_cnt  = rise_cnt + 1;
                cap       = {cap[DATA_W-1:0], sda_in};
                prev_rise = last_rise;
                last_rise = cyc;
            end
            if (scl_p && !scl_in) fall_cnt = fall_cnt + 1;
            if (scl_p && scl_in && sda_p && !sda_in) n_start = n_start + 1;
            if (scl_p && scl_in && !sda_p && sda_in) n_stop = n_stop + 1;
        end
        scl_p = scl_in;
        sda_p = sda_in;
    end

    i2c_cmd_master #(.DIV_W(DIV_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .div(div),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ack(cmd_ack),
        .tx_wr(tx_wr), .tx_byte(tx_byte), .clr_irq(clr_irq), .clr_wcol(clr_wcol),
        .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .busy(busy), .start_busy(start_busy), .stop_busy(stop_busy),
        .irq(irq), .wcol(wcol), .ack_stat(ack_stat), .rx_data(rx_data),
        .start_seen(start_seen), .stop_seen(stop_seen), .bus_free(bus_free)
    );

    int checks = 0, errors = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_period(input int d);
        return 4 * (d + 1);
    endfunction

    task automatic wait_idle();
        int n = 0;
        @(negedge clk);
        while (busy && n < 5000) begin
            @(negedge clk);
            n = n + 1;
        end
        if (n >= 5000) chk(1'b0, "busy-timeout", n, 0);
    endtask

    task automatic pulse_clr_irq();
        @(negedge clk) clr_irq = 1'b1;
        @(negedge clk) clr_irq = 1'b0;
    endtask

    task automatic issue(input logic [1:0] op, input logic ack);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_ack = ack;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic do_start();
        int s0;
        mode = 0; s0 = n_start;
        pulse_clr_irq();
        issue(2'd0, 1'b0);
        wait_idle();
        chk(irq == 1'b1, "R3 irq", int'(irq), 1);
        chk(start_busy == 1'b0 && scl_oe == 1'b1, "R3 held", int'(scl_oe), 1);
        chk(n_start == s0 + 1, "R3 start count", n_start, s0 + 1);
        chk(start_seen && !bus_free, "R11 start_seen", int'(bus_free), 0);
    endtask

    task automatic do_tx(input logic [DATA_W-1:0] b, input logic nack);
        int s0, p0;
        s0 = n_start; p0 = n_stop;
        base = fall_cnt; mode = 1; slv_nack = nack;
        pulse_clr_irq();
        @(negedge clk) begin tx_wr = 1'b1; tx_byte = b; end
        @(negedge clk) tx_wr = 1'b0;
        wait_idle();
        chk(cap[DATA_W:1] == b, "R4 byte", int'(cap[DATA_W:1]), int'(b));
        chk(ack_stat == nack && cap[0] == nack, "R4 ack", int'(ack_stat), int'(nack));
        chk(irq == 1'b1, "R4 irq", int'(irq), 1);
        chk(n_start == s0 && n_stop == p0, "R4 sda steady", n_start + n_stop, s0 + p0);
        chk(last_rise - prev_rise == exp_period(int'(div)), "R2 period",
            last_rise - prev_rise, exp_period(int'(div)));
        mode = 0;
    endtask

    task automatic do_rx(input logic [DATA_W-1:0] b, input logic ack);
        base = fall_cnt; mode = 2; slv_byte = b;
        pulse_clr_irq();
        issue(2'd3, ack);
        wait_idle();
        chk(rx_data == b, "R5 rx_data", int'(rx_data), int'(b));
        chk(cap[0] == ack, "R5 ack drive", int'(cap[0]), int'(ack));
        chk(irq == 1'b1, "R5 irq", int'(irq), 1);
        mode = 0;
    endtask

    task automatic do_rstart();
        int s0, p0;
        mode = 0; s0 = n_start; p0 = n_stop;
        pulse_clr_irq();
        issue(2'd1, 1'b0);
        wait_idle();
        chk(n_start == s0 + 1 && n_stop == p0, "R6 conditions", n_start - s0, 1);
        chk(irq && !start_busy && scl_oe && !bus_free, "R6 owned", int'(bus_free), 0);
    endtask

    task automatic do_stop();
        int p0;
        mode = 0; p0 = n_stop;
        pulse_clr_irq();
        issue(2'd2, 1'b0);
        wait_idle();
        chk(n_stop == p0 + 1, "R7 stop count", n_stop, p0 + 1);
        chk(!scl_oe && !sda_oe && !stop_busy, "R7 released", int'(scl_oe) + int'(sda_oe), 0);
        chk(irq == 1'b1, "R7 irq", int'(irq), 1);
        chk(stop_seen && bus_free, "R11 stop_seen", int'(stop_seen), 1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!scl_oe && !sda_oe, "R1 lines", int'(scl_oe) + int'(sda_oe), 0);
        chk(!busy && !irq && !wcol, "R1 flags", int'(busy) + int'(irq) + int'(wcol), 0);
        chk(bus_free == 1'b1, "R1 bus_free", int'(bus_free), 1);

        // R10: commands out of place
        issue(2'd2, 1'b0);
        @(negedge clk);
        chk(!busy && !stop_busy, "R10 stop idle ignored", int'(busy), 0);
        issue(2'd3, 1'b0);
        @(negedge clk);
        chk(!busy && !scl_oe, "R10 recv idle ignored", int'(busy), 0);

        // Directed minimum divider
        div = '0;
        do_start();
        do_tx(8'hA5, 1'b0);
        do_rx(8'h3C, 1'b1);
        issue(2'd0, 1'b0);
        @(negedge clk);
        chk(!busy && scl_oe, "R10 start while owned ignored", int'(busy), 0);
        do_rstart();
        do_stop();

        // Random trials
        for (int t = 0; t < 6; t++) begin
            div = DIV_W'($urandom % 6);
            do_start();
            do_tx(DATA_W'($urandom), 1'($urandom));
            do_rx(DATA_W'($urandom), 1'($urandom));
            if (($urandom % 2) == 0) begin
                do_rstart();
                do_tx(DATA_W'($urandom), 1'($urandom));
            end
            do_stop();
        end

        // R8: write during Start, then during Stop
        div = 8'd3;
        pulse_clr_irq();
        issue(2'd0, 1'b0);
        begin
            int r0;
            r0 = rise_cnt;
            @(negedge clk) tx_wr = 1'b1; tx_byte = 8'hFF;
            @(negedge clk) tx_wr = 1'b0;
            chk(wcol == 1'b1, "R8 wcol on start", int'(wcol), 1);
            wait_idle();
            repeat (30) @(negedge clk);
            chk(!busy && rise_cnt == r0, "R8 no transfer", rise_cnt - r0, 0);
            chk(scl_oe == 1'b1, "R8 still owned", int'(scl_oe), 1);
        end
        chk(wcol == 1'b1 && irq == 1'b1, "R9 sticky", int'(wcol) + int'(irq), 2);
        @(negedge clk) clr_wcol = 1'b1;
        @(negedge clk) clr_wcol = 1'b0;
        chk(wcol == 1'b0, "R9 wcol cleared", int'(wcol), 0);
        pulse_clr_irq();
        chk(irq == 1'b0, "R9 irq cleared", int'(irq), 0);
        do_tx(8'h5A, 1'b1);

        // R10: command during a byte is ignored
        base = fall_cnt; mode = 2; slv_byte = 8'hC3;
        issue(2'd3, 1'b0);
        issue(2'd2, 1'b0);
        wait_idle();
        chk(rx_data == 8'hC3 && scl_oe && !bus_free, "R10 busy cmd ignored", int'(rx_data), 8'hC3);
        mode = 0;

        // R8 during Stop
        issue(2'd2, 1'b0);
        @(negedge clk) tx_wr = 1'b1;
        @(negedge clk) tx_wr = 1'b0;
        wait_idle();
        chk(wcol == 1'b1 && !busy && !scl_oe, "R8 wcol on stop", int'(wcol), 1);

        // R11/R12: disable while owned
        do_start();
        @(negedge clk) en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(!start_seen && !stop_seen && bus_free, "R11 disable clears", int'(start_seen), 0);
        chk(!scl_oe && !sda_oe && !busy, "R12 released", int'(scl_oe), 0);
        issue(2'd0, 1'b0);
        @(negedge clk);
        chk(!busy && !scl_oe, "R12 cmd ignored", int'(busy), 0);
        en = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule